// File: doc/BRIEF.md
# Memory Request Budget Regulator

This block limits how many memory requests each of several processor cores may issue within one regulation period. Every request a core issues is counted, whatever its origin: the operating system on that core and the application running there draw on the same allowance. Once a core has used its full allowance, the block raises that core's throttle line, which stalls its further requests. The first refused attempt in a period produces a one-cycle overflow interrupt for that core.

A period-start pulse begins each regulation period. On that pulse every count returns to zero and a new set of budgets is taken from the budget input. The set is accepted only if the budgets together fit within a programmed period capacity. If they do not, the previous budgets stay in force and a configuration-error flag is raised. A global enable turns regulation off. While it is off, requests are still counted but no core is ever throttled.

Top module: `mem_req_budget_regulator`

## Requirements
- R1: After reset, all counts read 0, no interrupt is raised, the configuration-error flag is 0, and every active budget is 0. As a result, every core reads as throttled as soon as regulation is enabled, until the first period start.
- R2: Each accepted request from a core raises that core's count readback by one in the following cycle. Core i's count sits in bits [i*CNT_W +: CNT_W] of the count bus, and its budget sits in the same bits of the budget bus.
- R3: With regulation enabled, a core's throttle line is high whenever its count is at or above its active budget. A request seen while throttled is refused and is not counted.
- R4: The first refused request of a core in a period raises that core's overflow interrupt for exactly one cycle, in the cycle after the refusal. Later refusals in the same period raise no further interrupt.
- R5: A period-start pulse clears every count and every interrupt history. A request in the same cycle as the pulse is judged against the new budget and counted as the first request of the new period.
- R6: On a period start, the budget bus is loaded as the new set of active budgets only if the sum of all budgets is at most the period capacity. Otherwise the previous budgets remain active. The configuration-error flag becomes 1 in the cycle after a rejected period start and 0 after an accepted one. It changes at no other time.
- R7: While the enable is low, throttle lines stay low and no interrupt is raised, but requests are still counted.
- R8: A budget of zero throttles its core from the period-start cycle itself onward.
- R9: A change on the budget bus between period starts has no effect on throttling until the next period start.
- R10: A count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regEnable | input | 1 | Regulation on when high |
| periodStart | input | 1 | One-cycle pulse opening a new regulation period |
| reqIssued | input | NUM_CORES | Per-core memory request strobe |
| budgetVec | input | NUM_CORES*CNT_W | Per-core budgets, loaded on a period start |
| periodCapacity | input | SUM_W | Largest allowed sum of all budgets |
| throttle | output | NUM_CORES | Per-core stall line |
| overflowIrq | output | NUM_CORES | Per-core one-cycle overflow interrupt |
| countVec | output | NUM_CORES*CNT_W | Per-core request count readback |
| cfgError | output | 1 | Last period start carried an oversized budget set |

## Verification
The assertions assume that the period-start input is a pulse, and that a core may keep requesting while throttled; such requests are expected to be refused rather than to vanish. The assertions also assume that reset is held low across at least one clock edge before any check applies. The stimulus keeps every period-start pulse to one cycle and deliberately requests through the throttle to provoke overflow. It changes the budget bus only at period starts, except where it tests that a mid-period change is ignored.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  // Strobes passed from the control to the counting datapath
  typedef struct packed {
    logic clearPeriod;  // a new regulation period begins this cycle
    logic loadBudget;   // the budget bus is accepted this cycle
    logic regOn;        // regulation enabled
  } regStrobes_t;
endpackage

// File: rtl/mbr_ctrl.sv
module mbr_ctrl
  import mbr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W = 8,
  parameter int SUM_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       regEnable,
  input  logic                       periodStart,
  input  logic [NUM_CORES*CNT_W-1:0] budgetVec,
  input  logic [SUM_W-1:0]           periodCapacity,
  output regStrobes_t                strobes,
  output logic                       cfgError
);
  logic [SUM_W-1:0] budgetSum;
  logic             cfgOk;

  always_comb begin
    budgetSum = '0;
    for (int i = 0; i < NUM_CORES; i++)
      budgetSum = budgetSum + SUM_W'(budgetVec[i*CNT_W +: CNT_W]);
  end

  assign cfgOk = (budgetSum <= periodCapacity);

  always_comb begin
    strobes.clearPeriod = periodStart;
    strobes.loadBudget  = periodStart && cfgOk;
    strobes.regOn       = regEnable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           cfgError <= 1'b0;
    else if (periodStart) cfgError <= !cfgOk;
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(periodStart) |-> $stable(cfgError));
endmodule

// File: rtl/mbr_lane.sv
module mbr_lane
  import mbr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  regStrobes_t      strobes,
  input  logic [CNT_W-1:0] budgetNew,
  input  logic             reqIn,
  output logic             throttle,
  output logic             irq,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] budHeld, budEff, cntEff, cntNext;
  logic             fired, firedEff, blocked, accept, overEvt;

  // Replenish first, then judge this cycle's request in the new period
  assign budEff   = strobes.loadBudget ? budgetNew : budHeld;
  assign cntEff   = strobes.clearPeriod ? '0 : cnt;
  assign firedEff = strobes.clearPeriod ? 1'b0 : fired;
  assign blocked  = strobes.regOn && (cntEff >= budEff);
  assign accept   = reqIn && !blocked;
  assign overEvt  = reqIn && blocked && !firedEff;
  assign cntNext  = (accept && cntEff != CNT_MAX) ? cntEff + 1'b1 : cntEff;
  assign throttle = blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      budHeld <= '0;
      fired   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cnt   <= cntNext;
      fired <= firedEff | overEvt;
      irq   <= overEvt;
      if (strobes.loadBudget) budHeld <= budgetNew;
    end
  end

  // R3
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !strobes.clearPeriod) |=> $stable(cnt));
  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(reqIn && throttle));
  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clearPeriod && !reqIn) |=> (cnt == '0));
  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.regOn |=> !irq);
  // R9
  budget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.loadBudget |=> $stable(budHeld));
  // R10
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !strobes.clearPeriod) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/mbr_datapath.sv
module mbr_datapath
  import mbr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  regStrobes_t                strobes,
  input  logic [NUM_CORES-1:0]       reqIssued,
  input  logic [NUM_CORES*CNT_W-1:0] budgetVec,
  output logic [NUM_CORES-1:0]       throttle,
  output logic [NUM_CORES-1:0]       overflowIrq,
  output logic [NUM_CORES*CNT_W-1:0] countVec
);
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_lane
    mbr_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobes  (strobes),
      .budgetNew(budgetVec[g*CNT_W +: CNT_W]),
      .reqIn    (reqIssued[g]),
      .throttle (throttle[g]),
      .irq      (overflowIrq[g]),
      .cnt      (countVec[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/mem_req_budget_regulator.sv
module mem_req_budget_regulator
  import mbr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W = 8,
  localparam int SUM_W = CNT_W + $clog2(NUM_CORES) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       regEnable,
  input  logic                       periodStart,
  input  logic [NUM_CORES-1:0]       reqIssued,
  input  logic [NUM_CORES*CNT_W-1:0] budgetVec,
  input  logic [SUM_W-1:0]           periodCapacity,
  output logic [NUM_CORES-1:0]       throttle,
  output logic [NUM_CORES-1:0]       overflowIrq,
  output logic [NUM_CORES*CNT_W-1:0] countVec,
  output logic                       cfgError
);
  regStrobes_t strobes;

  mbr_ctrl #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .regEnable     (regEnable),
    .periodStart   (periodStart),
    .budgetVec     (budgetVec),
    .periodCapacity(periodCapacity),
    .strobes       (strobes),
    .cfgError      (cfgError)
  );

  mbr_datapath #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .reqIssued  (reqIssued),
    .budgetVec  (budgetVec),
    .throttle   (throttle),
    .overflowIrq(overflowIrq),
    .countVec   (countVec)
  );
endmodule

// File: tb/mem_req_budget_regulator_bench.sv
module mem_req_budget_regulator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int CW = 4;
  localparam int SW = CW + $clog2(NC) + 1;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regEnable = 1'b0;
  logic periodStart = 1'b0;
  logic [NC-1:0] reqIssued = '0;
  logic [NC*CW-1:0] budgetVec = '0;
  logic [SW-1:0] periodCapacity = '0;
  logic [NC-1:0] throttle, overflowIrq;
  logic [NC*CW-1:0] countVec;
  logic cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_req_budget_regulator #(.NUM_CORES(NC), .CNT_W(CW)) u_mem_req_budget_regulator (
    .clk(clk), .rst_n(rst_n), .regEnable(regEnable), .periodStart(periodStart),
    .reqIssued(reqIssued), .budgetVec(budgetVec), .periodCapacity(periodCapacity),
    .throttle(throttle), .overflowIrq(overflowIrq), .countVec(countVec),
    .cfgError(cfgError)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int cntOf(input int i);
    return int'(countVec[i*CW +: CW]);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); #1;
    for (int i = 0; i < NC; i++) check("R1 count", cntOf(i), 0);
    check("R1 throttle off", int'(throttle), 0);
    check("R1 irq", int'(overflowIrq), 0);
    check("R1 cfgError", int'(cfgError), 0);
    regEnable = 1'b1; #1;
    check("R1 zero active budgets throttle", int'(throttle), 7);

    // R2 R3 R4 R5 R8: sweep core 0 budget with a request every cycle
    for (int b = 0; b <= 6; b++) begin
      tick();
      budgetVec = {4'd1, 4'd1, 4'(b)};
      periodCapacity = SW'(15);
      periodStart = 1'b1;
      reqIssued = 3'b001;
      #1;
      check("R8 throttle in start cycle", int'(throttle[0]), (b == 0) ? 1 : 0);
      for (int k = 1; k <= b + 2; k++) begin
        tick();
        periodStart = 1'b0;
        #1;
        if (k == 1) check("R5 start-cycle request counted", cntOf(0), (b >= 1) ? 1 : 0);
        check("R2 count", cntOf(0), (k < b) ? k : b);
        check("R3 throttle", int'(throttle[0]), (k >= b) ? 1 : 0);
        check("R4 irq", int'(overflowIrq[0]), (k == b + 1) ? 1 : 0);
      end
      tick();
      reqIssued = '0;
      #1;
      check("R4 no second irq", int'(overflowIrq[0]), 0);
    end

    // R6: oversized set rejected; active budgets stay {1,1,6}
    tick();
    periodStart = 1'b1;
    periodCapacity = SW'(5);
    budgetVec = {4'd4, 4'd4, 4'd4};
    tick();
    periodStart = 1'b0;
    reqIssued = 3'b010;
    #1;
    check("R6 cfgError set", int'(cfgError), 1);
    check("R6 old budget allows first", int'(throttle[1]), 0);
    tick(); #1;
    check("R6 old budget of 1 kept", int'(throttle[1]), 1);
    check("R6 count under old budget", cntOf(1), 1);
    tick();
    reqIssued = '0;
    periodStart = 1'b1;
    periodCapacity = SW'(15);
    budgetVec = {4'd2, 4'd3, 4'd4};
    tick();
    periodStart = 1'b0;
    #1;
    check("R6 cfgError cleared", int'(cfgError), 0);
    reqIssued = 3'b010;
    repeat (3) tick();
    #1;
    check("R6 new budget 3 reached", int'(throttle[1]), 1);
    check("R6 new budget count", cntOf(1), 3);
    reqIssued = '0;

    // R9: mid-period budget change ignored
    tick();
    budgetVec = '0;
    reqIssued = 3'b001;
    #1;
    check("R9 change ignored", int'(throttle[0]), 0);
    tick(); #1;
    check("R9 count still rising", cntOf(0), 1);
    reqIssued = '0;

    // R7 R10: regulation off, counts saturate
    tick();
    regEnable = 1'b0;
    periodStart = 1'b1;
    budgetVec = {4'd1, 4'd1, 4'd1};
    reqIssued = 3'b010;
    for (int k = 0; k < 20; k++) begin
      tick();
      periodStart = 1'b0;
      #1;
      if (k % 5 == 4) begin
        check("R7 throttle off", int'(throttle), 0);
        check("R7 no irq", int'(overflowIrq), 0);
      end
    end
    check("R10 saturated count", cntOf(1), 15);
    check("R7 counted while off", cntOf(1), 15);
    regEnable = 1'b1; #1;
    check("R3 throttle on re-enable", int'(throttle[1]), 1);
    reqIssued = '0;
    tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule